// File: doc/BRIEF.md
# Integer Divide and Modulo Unit

This block is the iterative divider of a 64-bit integer datapath. It takes two 64-bit register operands and a function code, and it returns one 64-bit value for the destination register. That value is either the quotient or the remainder, never both. One datapath serves eight operations: the quotient or the remainder, signed or unsigned, at word (32-bit) or doubleword (64-bit) size. Division truncates toward zero. A zero divisor does not trap. Instead it yields a fixed, known result.

The surrounding pipeline presents the operands, the code and a size flag, and pulses `start`. The unit raises `busy` and runs one restoring step per cycle: 32 steps for a word, 64 for a doubleword. One further cycle applies the signs and the word extension. It then pulses `done` together with `rd_we`. An unknown code, or a doubleword request while 64-bit operations are disabled, is refused at once: `done` pulses with `ri_exc` and no write.

Top module: `idiv_unit`

## Requirements
- R1: The function code is decoded as follows. Bit 7 = 1 selects unsigned and bit 6 = 1 selects remainder. A word operation (`fn_dword`=0) is legal only if `fn_code` is 0100011000 (signed quotient), 0101011000 (signed remainder), 0110011000 (unsigned quotient) or 0111011000 (unsigned remainder). A doubleword operation (`fn_dword`=1) is legal only if `fn_code[8:0]` is 100011000, 101011000, 110011000 or 111011000, in that same order. Bit 9 is not examined for doubleword operations.
- R2: Signed division truncates toward zero. The quotient q and remainder r satisfy q*B + r = A, r takes the sign of A, and |r| < |B|.
- R3: Each completed operation gives exactly one value on `rd_data`, qualified by `rd_we`. That value is the quotient or the remainder, as the code selects.
- R4: Word operations ignore operand bits 63..32. Signed word operations read bits 31..0 as a signed 32-bit value, and unsigned word operations read them as an unsigned 32-bit value.
- R5: Every word result, signed or unsigned, has bits 63..32 equal to its bit 31.
- R6: Doubleword operations use the full 64-bit operands and return the 64-bit quotient or remainder unchanged.
- R7: An illegal code, or a legal doubleword code while `en64`=0, gives `done`=1 and `ri_exc`=1 with `rd_we`=0 in the cycle after the edge that samples `start`. In this case `busy` stays low.
- R8: A zero divisor raises no exception. The quotient is all ones and the remainder equals the dividend, taken at the operating width and then extended as in R5.
- R9: The most negative value divided by -1 gives the most negative value as quotient and zero as remainder, at the operating width.
- R10: Suppose `start` is sampled at edge E. Then `busy` is high from edge E until edge E+N+1, and `done` and `rd_we` are high for the one cycle after edge E+N+1. N is 32 for a word operation and 64 for a doubleword operation. `done` is never high while `busy` is high.
- R11: A `start` pulse seen while `busy` is high is ignored. It produces no extra result and does not change the result in progress.
- R12: A synchronous reset clears `busy`, `done`, `rd_we` and `ri_exc`. This includes a reset in the middle of an operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request pulse; sampled while not busy |
| fn_code | input | 10 | Function code selecting the operation |
| fn_dword | input | 1 | 1 = doubleword operation, 0 = word operation |
| en64 | input | 1 | 64-bit operations enabled |
| opnd_a | input | XLEN | Dividend register value |
| opnd_b | input | XLEN | Divisor register value |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_we | output | 1 | Destination write enable, with done |
| rd_data | output | XLEN | Quotient or remainder |
| ri_exc | output | 1 | Reserved-instruction exception, with done |

## Verification
The bench builds the unit with its default XLEN of 64, so the word size is 32. This lets both step counts, 32 and 64, run in one build. Both extremes, the 32-bit and 64-bit most negative values divided by -1, become reachable, as do word operands with unrelated bits in their upper halves. A reference model compares results using the simulator's own signed and unsigned arithmetic. The bench also measures completion latency for both sizes and checks the rejected path, a start pulse during a busy period, and a reset in the middle of an operation.

// File: rtl/idiv_pkg.sv
package idiv_pkg;

  // Function-code field positions
  localparam int unsigned FN_UNS_BIT = 7;
  localparam int unsigned FN_REM_BIT = 6;

  // Word codes (10 bits) and doubleword codes (9 bits)
  localparam logic [9:0] FN_W_SQ = 10'b0100011000;
  localparam logic [9:0] FN_W_SR = 10'b0101011000;
  localparam logic [9:0] FN_W_UQ = 10'b0110011000;
  localparam logic [9:0] FN_W_UR = 10'b0111011000;
  localparam logic [8:0] FN_D_SQ = 9'b100011000;
  localparam logic [8:0] FN_D_SR = 9'b101011000;
  localparam logic [8:0] FN_D_UQ = 9'b110011000;
  localparam logic [8:0] FN_D_UR = 9'b111011000;

  typedef struct packed {
    logic dword;
    logic uns;
    logic rem;
  } idiv_op_t;

  function automatic idiv_op_t decode_fn(input logic [9:0] code, input logic dword);
    idiv_op_t o;
    o.dword = dword;
    o.uns   = code[FN_UNS_BIT];
    o.rem   = code[FN_REM_BIT];
    return o;
  endfunction

  function automatic logic fn_legal(input logic [9:0] code, input logic dword);
    if (dword) return code[8] && (code[5:0] == 6'b011000);
    return (code[9:8] == 2'b01) && (code[5:0] == 6'b011000);
  endfunction

endpackage

// File: rtl/idiv_prep.sv
module idiv_prep #(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0] a_raw,
  input  logic [XLEN-1:0] b_raw,
  input  logic            dword,
  input  logic            uns,
  output logic [XLEN-1:0] a_mag,
  output logic [XLEN-1:0] b_mag,
  output logic            a_neg,
  output logic            b_neg,
  output logic            b_zero
);
  localparam int unsigned WL = XLEN / 2;

  // Bring an operand to the operating width, as a XLEN-bit value
  function automatic logic [XLEN-1:0] widen(input logic [XLEN-1:0] v, input logic dw,
                                            input logic sgn);
    if (dw) return v;
    if (sgn) return {{WL{v[WL-1]}}, v[WL-1:0]};
    return {{WL{1'b0}}, v[WL-1:0]};
  endfunction

  function automatic logic [XLEN-1:0] magnitude(input logic [XLEN-1:0] v, input logic neg);
    return neg ? (~v + 1'b1) : v;
  endfunction

  logic [XLEN-1:0] a_w, b_w;

  always_comb begin
    a_w    = widen(a_raw, dword, !uns);
    b_w    = widen(b_raw, dword, !uns);
    a_neg  = !uns && a_w[XLEN-1];
    b_neg  = !uns && b_w[XLEN-1];
    a_mag  = magnitude(a_w, a_neg);
    b_mag  = magnitude(b_w, b_neg);
    b_zero = (b_w == '0);
  end
endmodule

// File: rtl/idiv_core.sv
module idiv_core #(
  parameter int unsigned XLEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic            dword,
  input  logic [XLEN-1:0] a_mag,
  input  logic [XLEN-1:0] b_mag,
  output logic [XLEN-1:0] quo,
  output logic [XLEN-1:0] rem,
  output logic            idle
);
  localparam int unsigned WL = XLEN / 2;
  localparam int unsigned CW = $clog2(XLEN + 1);

  logic [CW-1:0]   cnt_q;
  logic [XLEN-1:0] quo_q, rem_q, div_q;
  logic [XLEN+1:0] diff_w;
  logic            take_w;

  // One restoring step: shift in the next dividend bit, try subtracting
  function automatic logic [XLEN+1:0] trial(input logic [XLEN-1:0] r, input logic nb,
                                            input logic [XLEN-1:0] d);
    return {1'b0, r, nb} - {2'b00, d};
  endfunction

  assign diff_w = trial(rem_q, quo_q[XLEN-1], div_q);
  assign take_w = (diff_w[XLEN+1:XLEN] == 2'b00);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      quo_q <= '0;
      rem_q <= '0;
      div_q <= '0;
    end else if (load) begin
      cnt_q <= dword ? CW'(XLEN) : CW'(WL);
      quo_q <= dword ? a_mag : {a_mag[WL-1:0], {WL{1'b0}}};
      rem_q <= '0;
      div_q <= b_mag;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
      quo_q <= {quo_q[XLEN-2:0], take_w};
      rem_q <= take_w ? diff_w[XLEN-1:0] : {rem_q[XLEN-2:0], quo_q[XLEN-1]};
    end
  end

  assign quo  = quo_q;
  assign rem  = rem_q;
  assign idle = (cnt_q == '0);
endmodule

// File: rtl/idiv_fix.sv
module idiv_fix #(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0] quo,
  input  logic [XLEN-1:0] rem,
  input  logic            a_neg,
  input  logic            b_neg,
  input  logic            b_zero,
  input  logic            dword,
  input  logic            rem_sel,
  output logic [XLEN-1:0] res
);
  localparam int unsigned WL = XLEN / 2;

  function automatic logic [XLEN-1:0] negate_if(input logic [XLEN-1:0] v, input logic n);
    return n ? (~v + 1'b1) : v;
  endfunction

  function automatic logic [XLEN-1:0] word_ext(input logic [XLEN-1:0] v);
    return {{WL{v[WL-1]}}, v[WL-1:0]};
  endfunction

  logic [XLEN-1:0] q_w, r_w, pick_w;

  always_comb begin
    q_w    = b_zero ? '1 : negate_if(quo, a_neg ^ b_neg);
    r_w    = negate_if(rem, a_neg);
    pick_w = rem_sel ? r_w : q_w;
    res    = dword ? pick_w : word_ext(pick_w);
  end
endmodule

// File: rtl/idiv_unit.sv
module idiv_unit
  import idiv_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [9:0]      fn_code,
  input  logic            fn_dword,
  input  logic            en64,
  input  logic [XLEN-1:0] opnd_a,
  input  logic [XLEN-1:0] opnd_b,
  output logic            busy,
  output logic            done,
  output logic            rd_we,
  output logic [XLEN-1:0] rd_data,
  output logic            ri_exc
);
  idiv_op_t        op_w, op_q;
  logic [XLEN-1:0] a_mag_w, b_mag_w, quo_w, rem_w, fix_w;
  logic            a_neg_w, b_neg_w, b_zero_w;
  logic            a_neg_q, b_neg_q, b_zero_q;
  logic            core_idle_w;

  // Named events for the checker
  logic accept_w, reject_w, launch_w, finish_w, run_dword_w;

  assign op_w        = decode_fn(fn_code, fn_dword);
  assign accept_w    = start && !busy;
  assign reject_w    = accept_w && (!fn_legal(fn_code, fn_dword) || (fn_dword && !en64));
  assign launch_w    = accept_w && !reject_w;
  assign finish_w    = busy && core_idle_w;
  assign run_dword_w = op_q.dword;

  idiv_prep #(.XLEN(XLEN)) u_prep (
    .a_raw(opnd_a), .b_raw(opnd_b), .dword(op_w.dword), .uns(op_w.uns),
    .a_mag(a_mag_w), .b_mag(b_mag_w), .a_neg(a_neg_w), .b_neg(b_neg_w), .b_zero(b_zero_w)
  );

  idiv_core #(.XLEN(XLEN)) u_core (
    .clk(clk), .rst(rst), .load(launch_w), .dword(op_w.dword),
    .a_mag(a_mag_w), .b_mag(b_mag_w), .quo(quo_w), .rem(rem_w), .idle(core_idle_w)
  );

  idiv_fix #(.XLEN(XLEN)) u_fix (
    .quo(quo_w), .rem(rem_w), .a_neg(a_neg_q), .b_neg(b_neg_q), .b_zero(b_zero_q),
    .dword(op_q.dword), .rem_sel(op_q.rem), .res(fix_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      rd_we    <= 1'b0;
      ri_exc   <= 1'b0;
      rd_data  <= '0;
      op_q     <= '0;
      a_neg_q  <= 1'b0;
      b_neg_q  <= 1'b0;
      b_zero_q <= 1'b0;
    end else begin
      done   <= 1'b0;
      rd_we  <= 1'b0;
      ri_exc <= 1'b0;
      if (launch_w) begin
        busy     <= 1'b1;
        op_q     <= op_w;
        a_neg_q  <= a_neg_w;
        b_neg_q  <= b_neg_w;
        b_zero_q <= b_zero_w;
      end
      if (reject_w) begin
        done   <= 1'b1;
        ri_exc <= 1'b1;
      end
      if (finish_w) begin
        busy    <= 1'b0;
        done    <= 1'b1;
        rd_we   <= 1'b1;
        rd_data <= fix_w;
      end
    end
  end
endmodule

// File: rtl/idiv_unit_chk.sv
module idiv_unit_chk #(
  parameter int unsigned XLEN = 64
) (
  input logic            clk,
  input logic            rst,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic            rd_we,
  input logic            ri_exc,
  input logic [XLEN-1:0] rd_data,
  input logic            launch,
  input logic            finish,
  input logic            run_dword
);
  localparam int unsigned WL = XLEN / 2;

  int unsigned lat_q;
  always_ff @(posedge clk) begin
    if (rst || launch) lat_q <= 0;
    else if (busy)     lat_q <= lat_q + 1;
  end

  a_r7_exc_no_write: assert property (@(posedge clk) disable iff (rst)
    ri_exc |-> (done && !rd_we));

  a_r3_write_with_done: assert property (@(posedge clk) disable iff (rst)
    rd_we |-> done);

  a_r10_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r5_word_ext: assert property (@(posedge clk) disable iff (rst)
    (rd_we && !run_dword) |-> (rd_data[XLEN-1:WL] == {WL{rd_data[WL-1]}}));

  a_r10_latency: assert property (@(posedge clk) disable iff (rst)
    rd_we |-> (lat_q == (run_dword ? XLEN : WL) + 1));

  a_r11_busy_hold: assert property (@(posedge clk) disable iff (rst)
    (busy && !finish) |=> busy);

  a_r11_busy_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

  a_r12_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> (!busy && !done && !rd_we && !ri_exc));
endmodule

bind idiv_unit idiv_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done), .rd_we(rd_we),
  .ri_exc(ri_exc), .rd_data(rd_data), .launch(launch_w), .finish(finish_w),
  .run_dword(run_dword_w)
);

// File: tb/sim_idiv_unit.sv
module sim_idiv_unit;
  import idiv_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [9:0]  fn_code = '0;
  logic        fn_dword = 1'b0;
  logic        en64 = 1'b1;
  logic [63:0] opnd_a = '0;
  logic [63:0] opnd_b = '0;
  logic        busy, done, rd_we, ri_exc;
  logic [63:0] rd_data;

  idiv_unit #(.XLEN(64)) u0 (
    .clk(clk), .rst(rst), .start(start), .fn_code(fn_code), .fn_dword(fn_dword),
    .en64(en64), .opnd_a(opnd_a), .opnd_b(opnd_b), .busy(busy), .done(done),
    .rd_we(rd_we), .rd_data(rd_data), .ri_exc(ri_exc)
  );

  always #10 clk = ~clk;

  typedef struct {
    logic [63:0] data;
    logic        we;
    logic        exc;
    int          t0;
    int          lat;
    string       tag;
  } exp_t;

  exp_t q_exp[$];
  int   n_chk = 0;
  int   n_err = 0;
  int   cyc = 0;
  bit   ended = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] wext(input logic [63:0] v);
    return {{32{v[31]}}, v[31:0]};
  endfunction

  // Reference model built from the requirements
  function automatic exp_t model(input logic [63:0] a, input logic [63:0] b,
                                 input logic [9:0] code, input logic dw, input logic en,
                                 input string tag);
    exp_t e;
    logic legal, uns, rm;
    logic [63:0] q, r, ua, ub;
    longint sa, sb;
    e.tag = tag; e.t0 = 0;
    legal = dw ? (code[8] && code[5:0] == 6'b011000)
               : (code[9:8] == 2'b01 && code[5:0] == 6'b011000);
    if (!legal || (dw && !en)) begin
      e.data = '0; e.we = 1'b0; e.exc = 1'b1; e.lat = 1;
      return e;
    end
    uns = code[7]; rm = code[6];
    if (uns) begin
      ua = dw ? a : {32'b0, a[31:0]};
      ub = dw ? b : {32'b0, b[31:0]};
      if (ub == 0) begin q = '1; r = ua; end
      else begin q = ua / ub; r = ua % ub; end
    end else begin
      sa = dw ? longint'(a) : longint'($signed(a[31:0]));
      sb = dw ? longint'(b) : longint'($signed(b[31:0]));
      if (sb == 0) begin q = '1; r = 64'(sa); end
      else if (sb == -1) begin q = ~64'(sa) + 64'd1; r = '0; end
      else begin q = 64'(sa / sb); r = 64'(sa % sb); end
    end
    e.data = rm ? r : q;
    if (!dw) e.data = wext(e.data);
    e.we = 1'b1; e.exc = 1'b0;
    e.lat = (dw ? 64 : 32) + 2;
    return e;
  endfunction

  task automatic wait_idle();
    while (busy || start) @(negedge clk);
  endtask

  task automatic issue(input logic [63:0] a, input logic [63:0] b, input logic [9:0] code,
                       input logic dw, input logic en, input string tag);
    exp_t e;
    wait_idle();
    e = model(a, b, code, dw, en, tag);
    e.t0 = cyc;
    q_exp.push_back(e);
    opnd_a = a; opnd_b = b; fn_code = code; fn_dword = dw; en64 = en;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // Monitor: pops expected items as results appear
  always @(negedge clk) begin
    if (!rst && done) begin
      if (q_exp.size() == 0) begin
        chk(1'b0, "R11 unexpected done", 64'(done), 64'd0);
      end else begin
        exp_t e;
        e = q_exp.pop_front();
        chk({rd_we, ri_exc} == {e.we, e.exc}, {e.tag, " we/exc"},
            64'({rd_we, ri_exc}), 64'({e.we, e.exc}));
        if (e.we) chk(rd_data == e.data, {e.tag, " data"}, rd_data, e.data);
        chk((cyc - e.t0) == e.lat, {"R10 latency ", e.tag}, 64'(cyc - e.t0), 64'(e.lat));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [63:0] s;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk({busy, done, rd_we, ri_exc} == 4'b0, "R12 reset state",
        64'({busy, done, rd_we, ri_exc}), 64'd0);

    // Signed word quotient and remainder, all sign mixes
    issue(64'd7, 64'd2, FN_W_SQ, 1'b0, 1'b1, "R2 7/2 q");
    issue(64'd7, 64'd2, FN_W_SR, 1'b0, 1'b1, "R3 7%2 r");
    issue(-64'sd7, 64'd2, FN_W_SQ, 1'b0, 1'b1, "R2 -7/2 q");
    issue(-64'sd7, 64'd2, FN_W_SR, 1'b0, 1'b1, "R2 -7%2 r");
    issue(64'd7, -64'sd2, FN_W_SR, 1'b0, 1'b1, "R2 7%-2 r");
    issue(-64'sd7, -64'sd2, FN_W_SQ, 1'b0, 1'b1, "R2 -7/-2 q");
    // Upper halves ignored for word operations
    issue(64'hDEAD_BEEF_0000_0010, 64'h1234_5678_0000_0003, FN_W_SQ, 1'b0, 1'b1, "R4 hi ignored q");
    issue(64'h0000_0000_FFFF_FFF9, 64'hFFFF_FFFF_0000_0002, FN_W_SR, 1'b0, 1'b1, "R4 hi ignored r");
    // Unsigned word with bit 31 set in the result
    issue(64'h0000_0000_FFFF_FFFF, 64'd1, FN_W_UQ, 1'b0, 1'b1, "R5 unsigned ext");
    issue(64'hFFFF_FFFF_FFFF_FFFF, 64'd2, FN_W_UQ, 1'b0, 1'b1, "R5 unsigned half");
    issue(64'h0000_0000_8000_0005, 64'h0000_0000_9000_0000, FN_W_UR, 1'b0, 1'b1, "R5 unsigned r");
    // Doubleword operations
    issue(64'h7FFF_0000_1234_5678, 64'h0000_0001_0000_0003, {1'b0, FN_D_SQ}, 1'b1, 1'b1, "R6 dword q");
    issue(64'h8000_0000_0000_0123, 64'h0000_0000_0001_0000, {1'b0, FN_D_SR}, 1'b1, 1'b1, "R6 dword r");
    issue(64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0007, {1'b0, FN_D_UQ}, 1'b1, 1'b1, "R6 dword uq");
    issue(64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0001, {1'b0, FN_D_UR}, 1'b1, 1'b1, "R6 dword ur");
    issue(64'h8000_0000_0000_0123, 64'h0000_0000_0001_0000, {1'b1, FN_D_SQ}, 1'b1, 1'b1, "R1 dword bit9");
    // Most negative by -1
    issue(64'h8000_0000_0000_0000, '1, {1'b0, FN_D_SQ}, 1'b1, 1'b1, "R9 dword min q");
    issue(64'h8000_0000_0000_0000, '1, {1'b0, FN_D_SR}, 1'b1, 1'b1, "R9 dword min r");
    issue(64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFFF, FN_W_SQ, 1'b0, 1'b1, "R9 word min q");
    issue(64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFFF, FN_W_SR, 1'b0, 1'b1, "R9 word min r");
    // Zero divisor
    issue(-64'sd5, 64'h1234_0000_0000_0000, FN_W_SQ, 1'b0, 1'b1, "R8 word zero q");
    issue(-64'sd5, 64'd0, FN_W_SR, 1'b0, 1'b1, "R8 word zero r");
    issue(64'h0000_0000_8000_0001, 64'd0, FN_W_UR, 1'b0, 1'b1, "R8 uword zero r");
    issue(64'h1234_5678_9ABC_DEF0, 64'd0, {1'b0, FN_D_UQ}, 1'b1, 1'b1, "R8 dword zero q");
    issue(-64'sd99, 64'd0, {1'b0, FN_D_SR}, 1'b1, 1'b1, "R8 dword zero r");
    // Rejections
    issue(64'd9, 64'd3, {1'b0, FN_D_SQ}, 1'b1, 1'b0, "R7 dword disabled");
    issue(64'd9, 64'd3, FN_W_SQ, 1'b0, 1'b0, "R7 word while disabled ok");
    issue(64'd9, 64'd3, 10'b0100011001, 1'b0, 1'b1, "R7 bad word code");
    issue(64'd9, 64'd3, 10'b1100011000, 1'b0, 1'b1, "R1 word bit9 set");
    issue(64'd9, 64'd3, 10'b0011011000, 1'b1, 1'b1, "R1 dword bit8 clear");

    // Start while busy is ignored
    issue(64'd1000, 64'd7, FN_W_SQ, 1'b0, 1'b1, "R11 first op");
    opnd_a = 64'd5; opnd_b = 64'd1; fn_code = FN_W_UR;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R11 still busy", 64'(busy), 64'd1);

    // Pseudo-random mix
    s = 64'h9E37_79B9_7F4A_7C15;
    for (int i = 0; i < 24; i++) begin
      logic [63:0] a, b;
      logic [9:0] code;
      logic dw;
      s = s ^ (s << 13); s = s ^ (s >> 7); s = s ^ (s << 17);
      a = s;
      s = s ^ (s << 13); s = s ^ (s >> 7); s = s ^ (s << 17);
      b = s >> s[5:0];
      dw = s[60];
      code = dw ? {1'b0, 3'b100, 6'b011000} : 10'b0100011000;
      code[7] = s[61];
      code[6] = s[62];
      issue(a, b, code, dw, 1'b1, "R2 mix");
    end

    // Reset in the middle of an operation
    wait_idle();
    @(negedge clk);
    issue(64'd12345, 64'd6, {1'b0, FN_D_SQ}, 1'b1, 1'b1, "R12 aborted");
    repeat (5) @(negedge clk);
    rst = 1'b1;
    q_exp.delete();
    @(negedge clk);
    chk({busy, done} == 2'b0, "R12 mid reset", 64'({busy, done}), 64'd0);
    rst = 1'b0;
    repeat (80) @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R12 no late done", 64'({busy, done}), 64'd0);
    issue(64'd12345, 64'd6, {1'b0, FN_D_SQ}, 1'b1, 1'b1, "R12 after reset");

    wait_idle();
    repeat (4) @(negedge clk);
    chk(q_exp.size() == 0, "R3 all results seen", 64'(q_exp.size()), 64'd0);
    if (!ended) begin
      ended = 1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule